// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block holds the software-visible control state for one port of general-purpose pins. Each pin has three control bits: a GPIO enable bit that takes the pin away from its primary function, an output-enable bit, and an output-value bit. Each control register has three word addresses on a small write/read register bus. The direct address overwrites the whole register. The set alias ORs the written word into it. The clear alias removes the written ones from it. Firmware can therefore change a single pin without a read-modify-write sequence.

A read-only input register returns the pin levels after a two-flop synchronizer, whatever mode each pin is in. The pin-side outputs are a per-pin select between GPIO and the primary function, a per-pin output enable and a per-pin drive value. These outputs go to the pad cells and the function muxes outside the block.

The bus front end is a two-state machine. ST_IDLE waits for a request. A read request with no write in the same cycle takes the transition IDLE_TO_RESP, and the read word is captured. ST_RESP presents the word for one cycle with `rd_valid` high. From ST_RESP, another read-only request takes RESP_TO_RESP and returns the next word. Any other cycle takes RESP_TO_IDLE. Without a read request, ST_IDLE stays in ST_IDLE (IDLE_HOLD). Writes are applied at the clock edge that samples them and do not change state.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the enable, output-enable and output registers are all 0. `pad_sel_gpio`, `pad_oe`, `pad_out` and `rd_valid` are 0.
- R2: A write to a direct address stores wdata[NPINS-1:0] in that register. The direct addresses are byte 0x00 for enable, 0x0C for output-enable and 0x18 for output. Without a write, no control register changes.
- R3: A write to a set alias sets every register bit whose wdata bit is 1 and leaves the bits written as 0 unchanged. The set aliases are 0x04 for enable, 0x10 for output-enable and 0x1C for output.
- R4: A write to a clear alias clears every register bit whose wdata bit is 1 and leaves the bits written as 0 unchanged. The clear aliases are 0x08 for enable, 0x14 for output-enable and 0x20 for output.
- R5: A read of a set-alias or clear-alias address returns the current value of its register.
- R6: For a pin whose enable bit is 0, `pad_sel_gpio`, `pad_oe` and `pad_out` are 0, whatever its output-enable and output bits are.
- R7: For a pin with enable 1 and output-enable 1, `pad_sel_gpio` and `pad_oe` are 1, and `pad_out` equals the output bit.
- R8: For a pin with enable 1 and output-enable 0, `pad_sel_gpio` is 1 and the pin is tri-stated. `pad_oe` is 0 and `pad_out` is 0.
- R9: The input register (byte 0x24) returns `pin_in` through two flops. A level present before clock edge k is returned by a read sampled at edge k+2 or later. A read sampled at edge k+1 still returns the previous level.
- R10: The input register returns the pin level in every mode: primary function, GPIO input and GPIO output. This holds even when the level differs from the output register.
- R11: `rd_valid` is high, with `rdata` holding the word, in the cycle after a read-only request. In any other cycle `rd_valid` and `rdata` are 0. Unmapped addresses read 0. Writes to the input register or to unmapped addresses change nothing.
- R12: If `wr_req` and `rd_req` are both high in one cycle, the write is applied and the read is dropped (no `rd_valid` follows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request for this cycle |
| rd_req | input | 1 | Read request for this cycle |
| addr | input | 6 | Byte address; bits 1:0 ignored |
| wdata | input | DATA_W | Write data; low NPINS bits used |
| rd_valid | output | 1 | Read word valid |
| rdata | output | DATA_W | Read word, zero-extended |
| pin_in | input | NPINS | Asynchronous pin levels |
| pad_sel_gpio | output | NPINS | 1 = GPIO owns the pin, 0 = primary function |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad drive value |

## Verification
The alias paths are exercised with mixed masks on registers that already hold mixed values. Because of this, a set alias that acts as a direct write, or a clear that inverts the wrong operand, gives a different read-back. The pad outputs are compared after every write against all three mode combinations on different pins at the same time. This separates the primary-function, tri-state and drive cases bit by bit. The input register is read one and two edges after a pin change, which exposes a missing or extra synchronizer stage. It is also read in output mode with a pin level opposite to the output register, which shows the read comes from the pin and not the register. Simultaneous read/write, writes to the input register and unmapped addresses cover the bus corner cases.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W  = 6;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int NUM_CTL = 3;

    typedef logic [IDX_W-1:0] widx_t;

    // Word indices; each control register owns three consecutive words
    localparam widx_t IX_EN      = 4'd0;
    localparam widx_t IX_EN_SET  = 4'd1;
    localparam widx_t IX_EN_CLR  = 4'd2;
    localparam widx_t IX_OE      = 4'd3;
    localparam widx_t IX_OE_SET  = 4'd4;
    localparam widx_t IX_OE_CLR  = 4'd5;
    localparam widx_t IX_OUT     = 4'd6;
    localparam widx_t IX_OUT_SET = 4'd7;
    localparam widx_t IX_OUT_CLR = 4'd8;
    localparam widx_t IX_PIN     = 4'd9;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;

    function automatic widx_t ctl_base(input int k);
        return widx_t'(3 * k);
    endfunction

endpackage

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg
    import gpio_bank_pkg::*;
#(
    parameter int    NPINS = 16,
    parameter widx_t BASE  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  widx_t            idx,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] q
);

    localparam widx_t SET_IX = BASE + widx_t'(1);
    localparam widx_t CLR_IX = BASE + widx_t'(2);

    logic [NPINS-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_stb) begin
            if (idx == BASE) begin
                nxt = wdata;
            end else if (idx == SET_IX) begin
                nxt = q | wdata;
            end else if (idx == CLR_IX) begin
                nxt = q & ~wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin,
    output logic [NPINS-1:0] pin_sync
);

    logic [STAGES-1:0][NPINS-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
        end
    end

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] oe,
    input  logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] sel_gpio,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic drive;
        assign drive       = en[p] & oe[p];
        assign sel_gpio[p] = en[p];
        assign pad_oe[p]   = drive;
        assign pad_out[p]  = drive & dout[p];
    end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_sel_gpio,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out
);

    widx_t            idx;
    logic             rd_take;
    logic [NPINS-1:0] ctl_q [NUM_CTL];
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] oe_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] pin_s;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    bus_state_t       state_q;
    bus_state_t       state_d;
    logic             unused_bits;

    assign idx         = addr[ADDR_W-1:2];
    assign rd_take     = rd_req & ~wr_req;
    assign unused_bits = ^{wdata, addr[1:0]};

    // Three control registers, each with direct/set/clear words
    for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
        gpio_ctl_reg #(
            .NPINS(NPINS),
            .BASE (ctl_base(k))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_stb(wr_req),
            .idx   (idx),
            .wdata (wdata[NPINS-1:0]),
            .q     (ctl_q[k])
        );
    end

    assign en_q  = ctl_q[0];
    assign oe_q  = ctl_q[1];
    assign out_q = ctl_q[2];

    gpio_in_sync #(
        .NPINS (NPINS),
        .STAGES(2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pin_in),
        .pin_sync(pin_s)
    );

    gpio_pin_mux #(
        .NPINS(NPINS)
    ) u_mux (
        .en      (en_q),
        .oe      (oe_q),
        .dout    (out_q),
        .sel_gpio(pad_sel_gpio),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    // Read word selection
    always_comb begin
        rd_word = '0;
        case (idx)
            IX_EN, IX_EN_SET, IX_EN_CLR:    rd_word[NPINS-1:0] = en_q;
            IX_OE, IX_OE_SET, IX_OE_CLR:    rd_word[NPINS-1:0] = oe_q;
            IX_OUT, IX_OUT_SET, IX_OUT_CLR: rd_word[NPINS-1:0] = out_q;
            IX_PIN:                         rd_word[NPINS-1:0] = pin_s;
            default:                        rd_word = '0;
        endcase
    end

    // Bus FSM: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bus FSM: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_take ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_take ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Bus FSM: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_take ? rd_word : '0;
        end
    end

    assign rd_valid = (state_q == ST_RESP);
    assign rdata    = rdata_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic              rd_req,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rd_valid,
    input logic [NPINS-1:0]  pad_sel_gpio,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  oe_q,
    input logic [NPINS-1:0]  out_q
);

    widx_t            ix;
    logic [NPINS-1:0] wd;
    assign ix = addr[ADDR_W-1:2];
    assign wd = wdata[NPINS-1:0];

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && ix == IX_OUT) |=> (out_q == $past(wd))); // R2
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> ($stable(en_q) && $stable(oe_q) && $stable(out_q))); // R2
    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && ix == IX_EN_SET) |=> (en_q == ($past(en_q) | $past(wd)))); // R3
    AST_CLEAR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && ix == IX_OE_CLR) |=> (oe_q == ($past(oe_q) & ~$past(wd)))); // R4
    AST_PRIMARY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~pad_sel_gpio) == '0)); // R6
    AST_DRIVE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & (pad_out ^ out_q)) == '0)); // R7
    AST_TRISTATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0)); // R8
    AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req) |=> rd_valid); // R11
    AST_WRITE_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !rd_valid); // R12

endmodule

bind gpio_port_bank gpio_port_chk #(
    .NPINS (NPINS),
    .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .rd_req      (rd_req),
    .addr        (addr),
    .wdata       (wdata),
    .rd_valid    (rd_valid),
    .pad_sel_gpio(pad_sel_gpio),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .en_q        (en_q),
    .oe_q        (oe_q),
    .out_q       (out_q)
);

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;

    localparam int NP = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [5:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pad_sel_gpio;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [NP-1:0] en_m = '0;
    logic [NP-1:0] oe_m = '0;
    logic [NP-1:0] out_m = '0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #4 clk = ~clk;

    gpio_port_bank #(.NPINS(NP), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata),
        .pin_in(pin_in), .pad_sel_gpio(pad_sel_gpio), .pad_oe(pad_oe),
        .pad_out(pad_out)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Pad model: R6 primary, R7 drive, R8 tri-state
    task automatic check_pads(input string tag);
        check({tag, " R6 R7 R8 sel"}, DW'(pad_sel_gpio), DW'(en_m));
        check({tag, " R6 R7 R8 oe"},  DW'(pad_oe),       DW'(en_m & oe_m));
        check({tag, " R6 R7 R8 out"}, DW'(pad_out),      DW'(en_m & oe_m & out_m));
    endtask

    task automatic model_write(input logic [5:0] a, input logic [NP-1:0] d);
        case (a[5:2])
            4'd0: en_m  = d;
            4'd1: en_m  = en_m | d;
            4'd2: en_m  = en_m & ~d;
            4'd3: oe_m  = d;
            4'd4: oe_m  = oe_m | d;
            4'd5: oe_m  = oe_m & ~d;
            4'd6: out_m = d;
            4'd7: out_m = out_m | d;
            4'd8: out_m = out_m & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [NP-1:0] d, input string tag);
        @(negedge clk);
        wr_req = 1'b1; addr = a; wdata = {16'hDEAD, d};
        @(negedge clk);
        wr_req = 1'b0;
        model_write(a, d);
        check_pads(tag);
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_req = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Monitor: pops expected read words as responses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    vectors++; errors++;
                    $display("FAIL R11 R12 unexpected rd_valid: actual 1 expected 0");
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end else begin
                check("R11 idle rdata zero", rdata, '0);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_valid", DW'(rd_valid), '0);
        check_pads("R1");
        rst_n = 1'b1;
        bus_read(6'h00, '0, "R1 en reset");
        bus_read(6'h0C, '0, "R1 oe reset");
        bus_read(6'h18, '0, "R1 out reset");

        // R2 direct writes
        bus_write(6'h00, 16'hA5C3, "R2 en");
        bus_write(6'h0C, 16'h0FF0, "R2 oe");
        bus_write(6'h18, 16'h3366, "R2 out");
        bus_read(6'h00, 32'h0000A5C3, "R2 en readback");
        bus_read(6'h0C, 32'h00000FF0, "R2 oe readback");
        bus_read(6'h18, 32'h00003366, "R2 out readback");

        // R3 set alias, R5 alias readback
        bus_write(6'h04, 16'h0F0C, "R3 en set");
        bus_read(6'h04, 32'h0000AFCF, "R3 R5 en set");
        bus_write(6'h1C, 16'h8001, "R3 out set");
        bus_read(6'h1C, 32'h0000B367, "R3 R5 out set");
        bus_write(6'h10, 16'h0000, "R3 zero set");
        bus_read(6'h0C, 32'h00000FF0, "R3 zero mask no change");

        // R4 clear alias, R5
        bus_write(6'h08, 16'h8141, "R4 en clr");
        bus_read(6'h08, 32'h00002E8E, "R4 R5 en clr");
        bus_write(6'h14, 16'h00F0, "R4 oe clr");
        bus_read(6'h14, 32'h00000F00, "R4 R5 oe clr");
        bus_write(6'h20, 16'h0000, "R4 zero clr");
        bus_read(6'h20, 32'h0000B367, "R4 R5 out unchanged");

        // R6/R7/R8 mixed mode per pin
        bus_write(6'h00, 16'h00FF, "R6 R7 R8 en");
        bus_write(6'h0C, 16'hF0F0, "R6 R7 R8 oe");
        bus_write(6'h18, 16'hAAAA, "R6 R7 R8 out");
        bus_write(6'h1C, 16'h5555, "R7 out set all");
        bus_write(6'h08, 16'h00FF, "R6 all primary");
        bus_write(6'h04, 16'hFFFF, "R7 R8 all gpio");

        // R9 two-flop sync timing, R10 output mode with opposite pin
        bus_write(6'h18, 16'h0000, "R10 out low");
        bus_read(6'h24, '0, "R9 pin before change");
        @(negedge clk);
        pin_in = 16'h3C5A;
        bus_read(6'h24, '0, "R9 one edge still old");
        bus_read(6'h24, 32'h00003C5A, "R9 R10 two edges new");
        bus_write(6'h00, 16'h0000, "R10 primary mode");
        @(negedge clk);
        pin_in = 16'hC3A5;
        repeat (2) @(negedge clk);
        bus_read(6'h24, 32'h0000C3A5, "R10 primary mode pin");

        // R11 unmapped and read-only addresses
        bus_write(6'h24, 16'hFFFF, "R11 write input reg");
        bus_write(6'h28, 16'hFFFF, "R11 write unmapped");
        bus_read(6'h00, 32'h00000000, "R11 en untouched");
        bus_read(6'h0C, 32'h0000F0F0, "R11 oe untouched");
        bus_read(6'h18, 32'h00000000, "R11 out untouched");
        bus_read(6'h3C, 32'h00000000, "R11 unmapped read");

        // R12 simultaneous write and read
        @(negedge clk);
        wr_req = 1'b1; rd_req = 1'b1; addr = 6'h00; wdata = 32'h00001234;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        check("R12 read dropped", DW'(rd_valid), '0);
        model_write(6'h00, 16'h1234);
        check_pads("R12 write applied");
        bus_read(6'h00, 32'h00001234, "R12 write applied readback");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            vectors++; errors++;
            $display("FAIL R11 missing responses: actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule